// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block collects up to 32 interrupt request lines and presents them to a processor as one interrupt output plus a small bank of word registers. The sensitivity of each line is fixed at build time: rising edge, falling edge, active-high level or active-low level. A detected event is latched in a status register. That register is combined with a per-line enable mask to give the pending set. A two-bit master enable gates the output.

Software reaches the registers through a plain synchronous register bus. The bus has a byte address, a write strobe, write data and combinational read data. Enable bits can be replaced as a whole word, or changed bit by bit through separate set and clear aliases, so no read-modify-write race is possible. Events are cleared by writing ones to an acknowledge register. A vector register gives the number of the lowest pending line, so a handler can dispatch without scanning the status word.

Top module: `intc_top`

## Requirements
- R1: After reset, status, enable and master enable are 0, the interrupt output is low and the vector register reads 0xFFFFFFFF.
- R2: The parameter SENSE_MAP gives each source two bits at [2n+1:2n], encoded as 0 rising edge, 1 falling edge, 2 level high, 3 level low. With the default map, source n uses code n mod 4.
- R3: An edge source sets its status bit (status read at byte offset 0x00, bit n for source n) one clock after the edge. The edge is detected against a sample of the input delayed by one clock. A held input does not set the bit again after it is acknowledged.
- R4: A level source sets its status bit on every clock at which the input is at its active level. An acknowledge clears the bit for one clock, and the bit is set again on the following clock if the input is still active.
- R5: Writing to offset 0x0C clears each status bit whose write-data bit is 1. An edge detected in the same clock as its acknowledge leaves the bit set.
- R6: Writing to offset 0x08 replaces the enable register, and reading 0x08 returns it.
- R7: Writing to offset 0x10 sets each enable bit whose write-data bit is 1 and leaves the others unchanged.
- R8: Writing to offset 0x14 clears each enable bit whose write-data bit is 1 and leaves the others unchanged.
- R9: Reading offset 0x04 returns status AND enable (pending).
- R10: Writing offset 0x1C stores write-data bits [1:0] as the master enable, which reads back zero-extended. The interrupt output is high exactly when the master enable is 3 and at least one pending bit is set.
- R11: Reading offset 0x18 returns the lowest-numbered pending source, or 0xFFFFFFFF when nothing is pending.
- R12: Writes to 0x00, 0x04 and 0x18 are ignored, as are writes at non-word-aligned or out-of-range addresses. Reads of 0x0C, 0x10 and 0x14 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqSrc | input | N | Interrupt request lines, synchronous to clk |
| busAddr | input | ADDR_W | Register byte address |
| busWr | input | 1 | Write strobe, acts at the rising clock edge |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Combinational read data for busAddr |
| irqOut | output | 1 | Interrupt to the processor |

## Verification
The assertions take the request lines to be already synchronous to the clock. They also take every write to land on a word-aligned offset, so that the set, clear and master-enable properties can decode the address directly. The stimulus changes the request lines only on the falling clock edge and draws bus addresses only from the eight aligned offsets. It biases master-enable writes towards the value 3 so that the output path stays open for much of the run.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int BUS_W = 32;

  typedef enum logic [1:0] {
    SENSE_RISE = 2'd0,
    SENSE_FALL = 2'd1,
    SENSE_HIGH = 2'd2,
    SENSE_LOW  = 2'd3
  } sense_e;

  typedef enum logic [2:0] {
    SEL_STATUS = 3'd0,
    SEL_PEND   = 3'd1,
    SEL_ENABLE = 3'd2,
    SEL_ACK    = 3'd3,
    SEL_SETEN  = 3'd4,
    SEL_CLREN  = 3'd5,
    SEL_VECTOR = 3'd6,
    SEL_MASTER = 3'd7
  } regSel_e;

  typedef struct packed {
    logic    wrEnable;
    logic    wrSet;
    logic    wrClear;
    logic    wrAck;
    logic    wrMaster;
    regSel_e rdSel;
  } ctrlStrobes_t;
endpackage

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  output ctrlStrobes_t      strobes
);
  localparam int IDX_LO = 2;
  localparam int IDX_HI = 4;

  logic    inRange;
  logic    aligned;
  logic    wrOk;
  regSel_e sel;

  assign inRange = (busAddr >> (IDX_HI + 1)) == '0;
  assign aligned = busAddr[IDX_LO-1:0] == '0;
  assign sel     = regSel_e'(busAddr[IDX_HI:IDX_LO]);
  assign wrOk    = busWr & inRange & aligned;

  always_comb begin
    strobes          = '0;
    // out-of-range reads are steered to a register that reads as zero
    strobes.rdSel    = inRange ? sel : SEL_ACK;
    strobes.wrEnable = wrOk && (sel == SEL_ENABLE);
    strobes.wrSet    = wrOk && (sel == SEL_SETEN);
    strobes.wrClear  = wrOk && (sel == SEL_CLREN);
    strobes.wrAck    = wrOk && (sel == SEL_ACK);
    strobes.wrMaster = wrOk && (sel == SEL_MASTER);
  end
endmodule

// File: rtl/intc_dpath.sv
module intc_dpath
  import intc_pkg::*;
#(
  parameter int               N         = 32,
  parameter logic [2*N-1:0]   SENSE_MAP = {(N/4){8'hE4}}
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [N-1:0]     irqSrc,
  input  logic [BUS_W-1:0] busWdata,
  input  ctrlStrobes_t     strobes,
  output logic [BUS_W-1:0] busRdata,
  output logic             irqOut,
  output logic [N-1:0]     statusQ,
  output logic [N-1:0]     enableQ,
  output logic [N-1:0]     pendingQ,
  output logic [BUS_W-1:0] vectorQ
);
  localparam logic [BUS_W-1:0] NO_VECTOR = '1;

  logic [N-1:0] prevQ;
  logic [N-1:0] hit;
  logic [N-1:0] isEdge;
  logic [N-1:0] wmask;
  logic [N-1:0] ackMask;
  logic [1:0]   masterQ;

  assign wmask   = busWdata[N-1:0];
  assign ackMask = strobes.wrAck ? wmask : '0;

  for (genvar gi = 0; gi < N; gi++) begin : g_src
    localparam logic [1:0] MODE = SENSE_MAP[2*gi +: 2];
    if (MODE == SENSE_RISE) begin : g_rise
      assign hit[gi]    = irqSrc[gi] & ~prevQ[gi];
      assign isEdge[gi] = 1'b1;
    end else if (MODE == SENSE_FALL) begin : g_fall
      assign hit[gi]    = ~irqSrc[gi] & prevQ[gi];
      assign isEdge[gi] = 1'b1;
    end else if (MODE == SENSE_HIGH) begin : g_high
      assign hit[gi]    = irqSrc[gi];
      assign isEdge[gi] = 1'b0;
    end else begin : g_low
      assign hit[gi]    = ~irqSrc[gi];
      assign isEdge[gi] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevQ   <= '0;
      statusQ <= '0;
      enableQ <= '0;
      masterQ <= '0;
    end else begin
      prevQ   <= irqSrc;
      // a fresh edge beats its own acknowledge; a level must drop for one cycle
      statusQ <= (statusQ & ~ackMask) | (hit & isEdge) | (hit & ~isEdge & ~ackMask);
      if (strobes.wrEnable)     enableQ <= wmask;
      else if (strobes.wrSet)   enableQ <= enableQ | wmask;
      else if (strobes.wrClear) enableQ <= enableQ & ~wmask;
      if (strobes.wrMaster)     masterQ <= busWdata[1:0];
    end
  end

  assign pendingQ = statusQ & enableQ;

  always_comb begin
    vectorQ = NO_VECTOR;
    for (int i = N - 1; i >= 0; i--) begin
      if (pendingQ[i]) vectorQ = BUS_W'(i);
    end
  end

  assign irqOut = (masterQ == 2'b11) && (|pendingQ);

  always_comb begin
    unique case (strobes.rdSel)
      SEL_STATUS: busRdata = BUS_W'(statusQ);
      SEL_PEND:   busRdata = BUS_W'(pendingQ);
      SEL_ENABLE: busRdata = BUS_W'(enableQ);
      SEL_VECTOR: busRdata = vectorQ;
      SEL_MASTER: busRdata = BUS_W'(masterQ);
      default:    busRdata = '0;
    endcase
  end
endmodule

// File: rtl/intc_top.sv
module intc_top
  import intc_pkg::*;
#(
  parameter int             N         = 32,
  parameter int             ADDR_W    = 5,
  parameter logic [2*N-1:0] SENSE_MAP = {(N/4){8'hE4}}
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [N-1:0]      irqSrc,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              irqOut
);
  ctrlStrobes_t     strobes;
  logic [N-1:0]     statusQ;
  logic [N-1:0]     enableQ;
  logic [N-1:0]     pendingQ;
  logic [BUS_W-1:0] vectorQ;

  intc_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busAddr (busAddr),
    .busWr   (busWr),
    .strobes (strobes)
  );

  intc_dpath #(.N(N), .SENSE_MAP(SENSE_MAP)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .irqSrc   (irqSrc),
    .busWdata (busWdata),
    .strobes  (strobes),
    .busRdata (busRdata),
    .irqOut   (irqOut),
    .statusQ  (statusQ),
    .enableQ  (enableQ),
    .pendingQ (pendingQ),
    .vectorQ  (vectorQ)
  );
endmodule

// File: rtl/intc_chk.sv
module intc_chk #(
  parameter int N      = 32,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWr,
  input logic [31:0]       busWdata,
  input logic              irqOut,
  input logic [N-1:0]      statusQ,
  input logic [N-1:0]      enableQ,
  input logic [N-1:0]      pendingQ,
  input logic [31:0]       vectorQ
);
  logic wrStatus, wrSetEn, wrClrEn, wrMaster;
  assign wrStatus = busWr && (busAddr == ADDR_W'(5'h00));
  assign wrSetEn  = busWr && (busAddr == ADDR_W'(5'h10));
  assign wrClrEn  = busWr && (busAddr == ADDR_W'(5'h14));
  assign wrMaster = busWr && (busAddr == ADDR_W'(5'h1C));

  AST_SET_EN_BITS: assert property (@(posedge clk) disable iff (!rstN)
    wrSetEn |=> ((enableQ & $past(busWdata[N-1:0])) == $past(busWdata[N-1:0]))); // R7
  AST_SET_EN_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    wrSetEn |=> ((enableQ & ~$past(busWdata[N-1:0])) == ($past(enableQ) & ~$past(busWdata[N-1:0])))); // R7
  AST_CLR_EN_BITS: assert property (@(posedge clk) disable iff (!rstN)
    wrClrEn |=> ((enableQ & $past(busWdata[N-1:0])) == '0)); // R8
  AST_MASTER_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (wrMaster && (busWdata[1:0] != 2'b11)) |=> !irqOut); // R10
  AST_STATUS_RO: assert property (@(posedge clk) disable iff (!rstN)
    wrStatus |=> (($past(statusQ) & ~statusQ) == '0)); // R12
  AST_VEC_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (pendingQ == '0) |-> (vectorQ == 32'hFFFF_FFFF)); // R11
  AST_VEC_IS_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    (pendingQ != '0) |-> ((vectorQ < 32'(N)) && pendingQ[vectorQ[4:0]])); // R11
endmodule

bind intc_top intc_chk #(.N(N), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busAddr  (busAddr),
  .busWr    (busWr),
  .busWdata (busWdata),
  .irqOut   (irqOut),
  .statusQ  (statusQ),
  .enableQ  (enableQ),
  .pendingQ (pendingQ),
  .vectorQ  (vectorQ)
);

// File: tb/intc_top_tb.sv
module intc_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] EDGE_MASK = 32'h3333_3333;
  localparam logic [31:0] IDLE_SRC  = 32'h8888_8888;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] irqSrc = IDLE_SRC;
  logic [4:0]  busAddr = '0;
  logic        busWr = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqOut;

  int checks = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [31:0] mStat = '0, mEn = '0, mPrev = '0;
  logic [1:0]  mMs = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intc_top #(.N(32), .ADDR_W(5), .SENSE_MAP(64'hE4E4_E4E4_E4E4_E4E4)) u_dut (
    .clk(clk), .rstN(rstN), .irqSrc(irqSrc), .busAddr(busAddr),
    .busWr(busWr), .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut)
  );

  function automatic logic [31:0] hitFn(logic [31:0] s, logic [31:0] p);
    logic [31:0] h;
    for (int n = 0; n < 32; n++) begin
      case (n % 4)
        0: h[n] = s[n] & ~p[n];
        1: h[n] = ~s[n] & p[n];
        2: h[n] = s[n];
        default: h[n] = ~s[n];
      endcase
    end
    return h;
  endfunction

  function automatic logic [31:0] vecFn(logic [31:0] p);
    for (int n = 0; n < 32; n++) if (p[n]) return 32'(n);
    return 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] readFn(logic [4:0] a);
    case (a)
      5'h00: return mStat;
      5'h04: return mStat & mEn;
      5'h08: return mEn;
      5'h18: return vecFn(mStat & mEn);
      5'h1C: return {30'd0, mMs};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tagFor(logic [4:0] a);
    case (a)
      5'h00: return "R3";
      5'h04: return "R9";
      5'h08: return "R6";
      5'h18: return "R11";
      5'h1C: return "R10";
      default: return "R12";
    endcase
  endfunction

  task automatic check(logic [31:0] act, logic [31:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // drive at the falling edge, check the combinational view, then advance the model
  task automatic step(logic [31:0] s, logic w, logic [4:0] a, logic [31:0] d, string tag);
    logic [31:0] ack, h;
    irqSrc = s; busWr = w; busAddr = a; busWdata = d;
    #1;
    check(busRdata, readFn(a), (tag == "") ? tagFor(a) : tag);
    check({31'd0, irqOut}, {31'd0, (mMs == 2'b11) && ((mStat & mEn) != 0)}, "R10");
    @(posedge clk);
    ack = (w && a == 5'h0C) ? d : 32'd0;
    h = hitFn(s, mPrev);
    mStat = (mStat & ~ack) | (h & EDGE_MASK) | (h & ~EDGE_MASK & ~ack);
    if (w) begin
      case (a)
        5'h08: mEn = d;
        5'h10: mEn = mEn | d;
        5'h14: mEn = mEn & ~d;
        5'h1C: mMs = d[1:0];
        default: ;
      endcase
    end
    mPrev = s;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      checks++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] s;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    step(IDLE_SRC, 0, 5'h00, 0, "R1");
    step(IDLE_SRC, 0, 5'h08, 0, "R1");
    step(IDLE_SRC, 0, 5'h18, 0, "R1");
    step(IDLE_SRC, 0, 5'h1C, 0, "R1");
    // R6 direct enable write, R10 master on
    step(IDLE_SRC, 1, 5'h08, 32'hFFFF_FFFF, "R1");
    step(IDLE_SRC, 1, 5'h1C, 32'h3, "R6");
    // R2 all lines low: only level-low sources (code 3) fire
    step(32'h0, 0, 5'h1C, 0, "R10");
    step(32'h0, 0, 5'h00, 0, "R2");
    check(busRdata, 32'h8888_8888, "R2");
    step(32'h0, 0, 5'h18, 0, "R11");
    check(busRdata, 32'd3, "R11");
    // R4 level re-asserts after acknowledge
    step(32'h0, 1, 5'h0C, 32'hFFFF_FFFF, "R5");
    step(32'h0, 0, 5'h00, 0, "R4");
    step(32'h0, 0, 5'h00, 0, "R4");
    step(IDLE_SRC, 1, 5'h0C, 32'hFFFF_FFFF, "R4");
    step(IDLE_SRC, 0, 5'h00, 0, "R5");
    // R3 rising edge on source 0, held
    step(IDLE_SRC | 32'h1, 0, 5'h00, 0, "R3");
    step(IDLE_SRC | 32'h1, 1, 5'h0C, 32'h1, "R3");
    step(IDLE_SRC | 32'h1, 0, 5'h00, 0, "R3");
    step(IDLE_SRC, 0, 5'h00, 0, "R3");
    // R5 edge in the same cycle as its acknowledge
    step(IDLE_SRC | 32'h10, 1, 5'h0C, 32'h10, "R5");
    step(IDLE_SRC, 0, 5'h00, 0, "R5");
    // R7 / R8 set and clear aliases
    step(IDLE_SRC, 1, 5'h08, 32'h0, "R6");
    step(IDLE_SRC, 1, 5'h10, 32'h00F0, "R6");
    step(IDLE_SRC, 1, 5'h14, 32'h0030, "R7");
    step(IDLE_SRC, 0, 5'h08, 0, "R8");
    // R12 writes to read-only words ignored, alias reads are zero
    step(IDLE_SRC, 1, 5'h00, 32'hFFFF_FFFF, "R9");
    step(IDLE_SRC, 1, 5'h04, 32'hFFFF_FFFF, "R12");
    step(IDLE_SRC, 1, 5'h18, 32'hFFFF_FFFF, "R12");
    step(IDLE_SRC, 0, 5'h00, 0, "R12");
    step(IDLE_SRC, 0, 5'h10, 0, "R12");
    step(IDLE_SRC, 0, 5'h14, 0, "R12");
    // R11 nothing enabled
    step(IDLE_SRC, 1, 5'h08, 32'h0, "R12");
    step(IDLE_SRC, 0, 5'h18, 0, "R11");
    // random traffic
    s = IDLE_SRC;
    for (int i = 0; i < 4000; i++) begin
      logic [4:0]  a;
      logic        w;
      logic [31:0] d;
      s = s ^ ($urandom & $urandom & $urandom);
      a = {3'($urandom % 8), 2'b00};
      w = ($urandom % 3) == 0;
      d = $urandom;
      if (a == 5'h1C && ($urandom % 2) == 1) d = 32'h3;
      if (a == 5'h0C && ($urandom % 4) == 0) d = 32'hFFFF_FFFF;
      step(s, w, a, d, "");
    end
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule